// File: doc/BRIEF.md
# Clock Manager Reconfiguration Sequencer

This block reprograms a clock-synthesis primitive through its dynamic reconfiguration port. When `start` is accepted, it samples eleven 16-bit setting words and puts the primitive into reset. It then writes the words one after another to a fixed list of register addresses. After each write it waits for the port's ready handshake before it starts the next access.

When the last write has been acknowledged, the sequencer releases the primitive's reset and waits for the lock input. Once lock is seen, it pulses `done`. A sticky `locked` output then reports whether lock has held since that completion.

A single register read can also be requested while the sequencer is idle, for readback. A programmable cycle limit bounds every wait for ready or lock. If that limit runs out, the run is aborted with an error.

Top module: `clkcfg_seq`

## Requirements
- R1: `prim_rst` goes high on the clock edge that accepts `start`. It stays high through every configuration write. It falls only on the edge where the eleventh write's ready is seen, or on an abort.
- R2: Slot k (k = 0..10) of `cfg_words` is bits [16k+15:16k]. Slot k is written to address 0x08, 0x09, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1A, 0x28, 0x4E, 0x4F respectively, in that order, one write per slot.
- R3: Every access drives `drp_en` high for exactly one cycle. On a write, `drp_we` is high in that same cycle. `drp_we` is never high without `drp_en`.
- R4: After a strobe, no further strobe occurs until `drp_rdy` has been seen high, however many cycles ready takes.
- R5: A read requested with `rd_req` in idle strobes `rd_addr` with `drp_we` low. It then presents the `drp_do` value seen with ready on `rd_data`, with a one-cycle `rd_valid` pulse.
- R6: `done` is a one-cycle pulse issued only after `prim_locked` has been sampled high following the reset release. `busy` is low from the cycle in which `done` is high.
- R7: `busy` is high from the cycle after an accepted `start` until completion or abort. A `start` while not idle is ignored: no extra writes occur. Words are sampled only at acceptance.
- R8: If ready stays low for `tmo_limit` cycles after a strobe, the run aborts. `err` rises, `prim_rst` and `busy` drop, and no further writes occur.
- R9: If lock stays low for `tmo_limit` cycles after the reset release, the run aborts with `err` and without `done`.
- R10: `locked` rises together with `done`. It falls once `prim_locked` is seen low, and stays low even if lock returns, until the next completion. It is cleared when a new `start` is accepted.
- R11: After reset, `busy`, `done`, `err`, `locked`, `prim_rst`, `drp_en`, `drp_we` and `rd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port and sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a full reconfiguration run |
| rd_req | input | 1 | Request one register read (idle only) |
| rd_addr | input | 7 | Address for the read |
| cfg_words | input | 176 | Eleven setting words, slot k at bits [16k+15:16k] |
| tmo_limit | input | 16 | Cycle limit for each wait on ready or lock |
| drp_addr | output | 7 | Port address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_en | output | 1 | Port access strobe |
| drp_we | output | 1 | Port write strobe |
| drp_rdy | input | 1 | Port access complete |
| prim_rst | output | 1 | Reset to the clock primitive |
| prim_locked | input | 1 | Lock indication from the primitive |
| busy | output | 1 | Reconfiguration run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run or read aborted on a timeout |
| locked | output | 1 | Lock held since the last completion |
| rd_data | output | 16 | Readback data |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` is valid |

## Verification
A corrupted slot index appears at once on the port as a wrong address or data word, or as a count other than eleven writes. An access engine that loses its waiting state produces a second strobe before ready. The port model detects that in the same cycle. A reset flag or lock-wait state that is out of step shows up as a write logged with the primitive out of reset, as `done` without lock, or as a missing `err` within `tmo_limit` cycles of a stall.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   localparam int CFG_COUNT = 11;
   localparam int SLOT_W    = $clog2(CFG_COUNT);

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_WR_GO,
      SQ_WR_WAIT,
      SQ_LOCK_WAIT,
      SQ_RD_GO,
      SQ_RD_WAIT
   } seq_state_t;

   typedef enum logic [1:0] {
      PE_IDLE,
      PE_STROBE,
      PE_WAIT
   } port_state_t;

   // target register for each configuration slot; the order is the write order
   function automatic logic [6:0] slot_addr(input logic [SLOT_W-1:0] slot);
      logic [6:0] a;
      case (slot)
         4'd0:    a = 7'h08;
         4'd1:    a = 7'h09;
         4'd2:    a = 7'h14;
         4'd3:    a = 7'h15;
         4'd4:    a = 7'h16;
         4'd5:    a = 7'h18;
         4'd6:    a = 7'h19;
         4'd7:    a = 7'h1A;
         4'd8:    a = 7'h28;
         4'd9:    a = 7'h4E;
         default: a = 7'h4F;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/clkcfg_wait_timer.sv
module clkcfg_wait_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);

   if (TMO_W < 2) begin : g_bad_tmo
      $error("clkcfg_wait_timer: TMO_W must be at least 2");
   end

   logic [TMO_W-1:0] cnt_q;

   // counts cycles spent in the current wait, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != {TMO_W{1'b1}}) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/clkcfg_word_bank.sv
module clkcfg_word_bank
   import clkcfg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COUNT  = CFG_COUNT,
   localparam int IDX_W = $clog2(COUNT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [COUNT*DATA_W-1:0] words_in,
   input  logic [IDX_W-1:0]        idx,
   output logic [DATA_W-1:0]       word_out
);

   if (COUNT < 2) begin : g_bad_count
      $error("clkcfg_word_bank: COUNT must be at least 2");
   end

   logic [COUNT-1:0][DATA_W-1:0] words_split;
   logic [COUNT-1:0][DATA_W-1:0] slot_q;

   for (genvar g = 0; g < COUNT; g++) begin : g_split
      assign words_split[g] = words_in[g*DATA_W +: DATA_W];
   end

   // snapshot taken only when a run is accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (load) begin
         slot_q <= words_split;
      end
   end

   always_comb begin
      word_out = '0;
      for (int i = 0; i < COUNT; i++) begin
         if (idx == IDX_W'(i)) word_out = slot_q[i];
      end
   end

endmodule

// File: rtl/clkcfg_port_engine.sv
module clkcfg_port_engine
   import clkcfg_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_we,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic [DATA_W-1:0] go_data,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic [ADDR_W-1:0] drp_addr,
   output logic [DATA_W-1:0] drp_di,
   output logic              drp_en,
   output logic              drp_we,
   input  logic [DATA_W-1:0] drp_do,
   input  logic              drp_rdy,
   output logic              ack,
   output logic              tmo,
   output logic [DATA_W-1:0] rdata,
   output logic              engine_idle
);

   port_state_t pst_q;
   logic        wait_run;
   logic        wait_exp;

   assign wait_run = (pst_q == PE_WAIT);

   clkcfg_wait_timer #(.TMO_W(TMO_W)) u_rdy_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (wait_run),
      .limit   (tmo_limit),
      .expired (wait_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pst_q    <= PE_IDLE;
         drp_addr <= '0;
         drp_di   <= '0;
         drp_en   <= 1'b0;
         drp_we   <= 1'b0;
         rdata    <= '0;
      end else begin
         case (pst_q)
            PE_IDLE: begin
               if (go) begin
                  drp_addr <= go_addr;
                  drp_di   <= go_data;
                  drp_en   <= 1'b1;
                  drp_we   <= go_we;
                  pst_q    <= PE_STROBE;
               end
            end
            PE_STROBE: begin
               drp_en <= 1'b0;
               drp_we <= 1'b0;
               pst_q  <= PE_WAIT;
            end
            PE_WAIT: begin
               if (drp_rdy) begin
                  rdata <= drp_do;
                  pst_q <= PE_IDLE;
               end else if (wait_exp) begin
                  pst_q <= PE_IDLE;
               end
            end
            default: pst_q <= PE_IDLE;
         endcase
      end
   end

   assign ack         = wait_run && drp_rdy;
   assign tmo         = wait_run && !drp_rdy && wait_exp;
   assign engine_idle = (pst_q == PE_IDLE);

   // R3: strobe lasts one cycle
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      drp_en |=> !drp_en);
   // R3: write strobe only together with enable
   a_r3_we_with_en: assert property (@(posedge clk) disable iff (!rst_n)
      drp_we |-> drp_en);
   // R4: a request from the sequencer never arrives while an access is open
   a_r4_no_go_while_open: assert property (@(posedge clk) disable iff (!rst_n)
      (!engine_idle) |-> !go);

endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
   import clkcfg_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int DATA_W  = 16,
   parameter int TMO_W   = 16,
   localparam int NWORDS = CFG_COUNT,
   localparam int IDX_W  = SLOT_W,
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     rd_req,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [NWORDS*DATA_W-1:0] cfg_words,
   input  logic [TMO_W-1:0]         tmo_limit,
   output logic [ADDR_W-1:0]        drp_addr,
   output logic [DATA_W-1:0]        drp_di,
   input  logic [DATA_W-1:0]        drp_do,
   output logic                     drp_en,
   output logic                     drp_we,
   input  logic                     drp_rdy,
   output logic                     prim_rst,
   input  logic                     prim_locked,
   output logic                     busy,
   output logic                     done,
   output logic                     err,
   output logic                     locked,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_valid
);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("clkcfg_seq: ADDR_W must hold address 0x4F");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("clkcfg_seq: DATA_W must be positive");
   end

   seq_state_t        st_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [DATA_W-1:0] slot_word;
   logic              bank_load;
   logic              go;
   logic              go_we;
   logic [ADDR_W-1:0] go_addr;
   logic [DATA_W-1:0] go_data;
   logic              ack;
   logic              tmo;
   logic              engine_idle;
   logic              lock_run;
   logic              lock_exp;

   assign bank_load = (st_q == SQ_IDLE) && start;

   clkcfg_word_bank #(.DATA_W(DATA_W), .COUNT(NWORDS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bank_load),
      .words_in (cfg_words),
      .idx      (idx_q),
      .word_out (slot_word)
   );

   assign go      = (st_q == SQ_WR_GO) || (st_q == SQ_RD_GO);
   assign go_we   = (st_q == SQ_WR_GO);
   assign go_addr = (st_q == SQ_WR_GO) ? ADDR_W'(slot_addr(idx_q)) : rd_addr_q;
   assign go_data = (st_q == SQ_WR_GO) ? slot_word : '0;

   clkcfg_port_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .go_we       (go_we),
      .go_addr     (go_addr),
      .go_data     (go_data),
      .tmo_limit   (tmo_limit),
      .drp_addr    (drp_addr),
      .drp_di      (drp_di),
      .drp_en      (drp_en),
      .drp_we      (drp_we),
      .drp_do      (drp_do),
      .drp_rdy     (drp_rdy),
      .ack         (ack),
      .tmo         (tmo),
      .rdata       (rd_data),
      .engine_idle (engine_idle)
   );

   assign lock_run = (st_q == SQ_LOCK_WAIT);

   clkcfg_wait_timer #(.TMO_W(TMO_W)) u_lock_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (lock_run),
      .limit   (tmo_limit),
      .expired (lock_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         idx_q     <= '0;
         rd_addr_q <= '0;
         prim_rst  <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         locked    <= 1'b0;
         rd_valid  <= 1'b0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         if (locked && !prim_locked) locked <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  busy     <= 1'b1;
                  err      <= 1'b0;
                  locked   <= 1'b0;
                  prim_rst <= 1'b1;
                  idx_q    <= '0;
                  st_q     <= SQ_WR_GO;
               end else if (rd_req) begin
                  rd_addr_q <= rd_addr;
                  st_q      <= SQ_RD_GO;
               end
            end
            SQ_WR_GO: st_q <= SQ_WR_WAIT;
            SQ_WR_WAIT: begin
               if (ack) begin
                  if (idx_q == LAST_IDX) begin
                     prim_rst <= 1'b0;
                     st_q     <= SQ_LOCK_WAIT;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= SQ_WR_GO;
                  end
               end else if (tmo) begin
                  prim_rst <= 1'b0;
                  err      <= 1'b1;
                  busy     <= 1'b0;
                  st_q     <= SQ_IDLE;
               end
            end
            SQ_LOCK_WAIT: begin
               if (prim_locked) begin
                  done   <= 1'b1;
                  busy   <= 1'b0;
                  locked <= 1'b1;
                  st_q   <= SQ_IDLE;
               end else if (lock_exp) begin
                  err  <= 1'b1;
                  busy <= 1'b0;
                  st_q <= SQ_IDLE;
               end
            end
            SQ_RD_GO: st_q <= SQ_RD_WAIT;
            SQ_RD_WAIT: begin
               if (ack) begin
                  rd_valid <= 1'b1;
                  st_q     <= SQ_IDLE;
               end else if (tmo) begin
                  err  <= 1'b1;
                  st_q <= SQ_IDLE;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // R1: every write strobe happens with the primitive in reset
   a_r1_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (drp_en && drp_we) |-> prim_rst);
   // R6: completion only after lock was sampled
   a_r6_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(prim_locked));
   // R6: completion is a single-cycle pulse, not busy
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));
   // R8: an abort leaves the primitive out of reset
   a_r8_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !prim_rst);
   // R10: locked status never claims lock the primitive does not report
   a_r10_locked_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !done) |-> $past(prim_locked));

endmodule

// File: tb/sim_clkcfg_seq.sv
`timescale 1ns/1ps
module sim_clkcfg_seq;

   localparam int AW = 7;
   localparam int DW = 16;
   localparam int NW = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [NW*DW-1:0] cfg_words = '0;
   logic [15:0] tmo_limit = 16'd200;
   logic [AW-1:0] drp_addr;
   logic [DW-1:0] drp_di;
   logic [DW-1:0] drp_do = '0;
   logic drp_en, drp_we;
   logic drp_rdy = 1'b0;
   logic prim_rst;
   logic prim_locked = 1'b0;
   logic busy, done, err, locked, rd_valid;
   logic [DW-1:0] rd_data;

   always #2 clk = ~clk;

   clkcfg_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
      .cfg_words(cfg_words), .tmo_limit(tmo_limit),
      .drp_addr(drp_addr), .drp_di(drp_di), .drp_do(drp_do), .drp_en(drp_en),
      .drp_we(drp_we), .drp_rdy(drp_rdy), .prim_rst(prim_rst), .prim_locked(prim_locked),
      .busy(busy), .done(done), .err(err), .locked(locked),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // expected write order (R2)
   logic [6:0] exp_addr [NW] = '{7'h08, 7'h09, 7'h14, 7'h15, 7'h16, 7'h18,
                                 7'h19, 7'h1A, 7'h28, 7'h4E, 7'h4F};

   // ---------------- port model ----------------
   logic [15:0] mem [128];
   int  lat = 2;
   bit  block_rdy = 1'b0;
   bit  pend = 1'b0;
   int  cnt = 0;
   logic [6:0] paddr = '0;
   bit  en_prev = 1'b0;
   int  wide_cnt = 0, overlap_cnt = 0, weerr_cnt = 0;
   logic [6:0]  log_addr [64];
   logic [15:0] log_data [64];
   bit          log_rst  [64];
   int  log_n = 0;
   int  rd_n = 0;
   logic [6:0] rd_last = '0;
   int  done_cnt = 0;

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 16'hA500 + 16'(i);
   end

   always @(posedge clk) begin
      drp_rdy <= 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            drp_rdy <= 1'b1;
            drp_do  <= mem[paddr];
            pend    <= 1'b0;
         end else cnt <= cnt - 1;
      end
      if (drp_en) begin
         if (pend) overlap_cnt++;
         if (en_prev) wide_cnt++;
         if (!block_rdy) begin
            pend  <= 1'b1;
            cnt   <= lat;
            paddr <= drp_addr;
         end
         if (drp_we) begin
            mem[drp_addr] = drp_di;
            if (log_n < 64) begin
               log_addr[log_n] = drp_addr;
               log_data[log_n] = drp_di;
               log_rst[log_n]  = prim_rst;
            end
            log_n++;
         end else begin
            rd_n++;
            rd_last = drp_addr;
         end
      end
      if (drp_we && !drp_en) weerr_cnt++;
      en_prev <= drp_en;
      if (done) done_cnt++;
   end

   // ---------------- lock model ----------------
   int lock_delay = 10;
   bit lock_never = 1'b0;
   bit lock_drop = 1'b0;
   int lcnt = 0;
   always @(posedge clk) begin
      if (prim_rst || lock_never || lock_drop) begin
         prim_locked <= 1'b0;
         lcnt <= 0;
      end else if (lcnt >= lock_delay) prim_locked <= 1'b1;
      else lcnt <= lcnt + 1;
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NW*DW-1:0] make_words(input logic [15:0] seed);
      logic [NW*DW-1:0] w;
      for (int k = 0; k < NW; k++) w[k*DW +: DW] = seed ^ (16'h1111 * 16'(k + 1));
      return w;
   endfunction

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // polls at negedge; which: 0 done, 1 err, 2 rd_valid
   task automatic wait_for(input int which, input int maxc, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < maxc && !seen; i++) begin
         @(negedge clk);
         case (which)
            0: seen = done;
            1: seen = err;
            default: seen = rd_valid;
         endcase
      end
   endtask

   task automatic check_log(input logic [NW*DW-1:0] w, input int base, input string tag);
      for (int k = 0; k < NW; k++) begin
         check(log_addr[base+k] == exp_addr[k], "R2 addr", 32'(log_addr[base+k]), 32'(exp_addr[k]));
         check(log_data[base+k] == w[k*DW +: DW], {tag, " data"}, 32'(log_data[base+k]),
               32'(w[k*DW +: DW]));
         check(log_rst[base+k] == 1'b1, "R1 rst held", 32'(log_rst[base+k]), 32'd1);
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      check(!busy && !done && !err && !locked, "R11 status idle", {busy, done, err, locked}, 0);
      check(!prim_rst && !drp_en && !drp_we && !rd_valid, "R11 port idle",
            {prim_rst, drp_en, drp_we, rd_valid}, 0);
   endtask

   task automatic t_config(input logic [15:0] seed, input int l, input string tag);
      bit seen;
      int base = log_n;
      int dbase = done_cnt;
      logic [NW*DW-1:0] w = make_words(seed);
      lat = l;
      cfg_words = w;
      pulse_start();
      check(prim_rst == 1'b1, "R1 rst at accept", 32'(prim_rst), 1);
      check(busy == 1'b1, "R7 busy", 32'(busy), 1);
      wait_for(0, 3000, seen);
      check(seen, "R6 done seen", 32'(seen), 1);
      check(prim_locked == 1'b1, "R6 lock at done", 32'(prim_locked), 1);
      check(!busy, "R6 busy low at done", 32'(busy), 0);
      check(!prim_rst, "R1 rst released", 32'(prim_rst), 0);
      check(locked, "R10 locked at done", 32'(locked), 1);
      check(!err, "R8 no err", 32'(err), 0);
      check(log_n - base == NW, "R2 write count", 32'(log_n - base), NW);
      check_log(w, base, tag);
      @(negedge clk);
      check(done_cnt - dbase == 1 && !done, "R6 single pulse", 32'(done_cnt - dbase), 1);
      check(wide_cnt == 0 && weerr_cnt == 0, "R3 strobe shape", 32'(wide_cnt + weerr_cnt), 0);
      check(overlap_cnt == 0, "R4 no overlap", 32'(overlap_cnt), 0);
   endtask

   task automatic t_ignore_start();
      bit seen;
      int base = log_n;
      logic [NW*DW-1:0] w = make_words(16'h3C5A);
      lat = 6;
      cfg_words = w;
      pulse_start();
      repeat (15) @(negedge clk);
      cfg_words = make_words(16'hFFFF);
      pulse_start();
      wait_for(0, 3000, seen);
      check(seen, "R7 done", 32'(seen), 1);
      check(log_n - base == NW, "R7 only one run", 32'(log_n - base), NW);
      check_log(w, base, "R7 sampled words");
      check(overlap_cnt == 0, "R4 slow ready", 32'(overlap_cnt), 0);
      repeat (30) @(negedge clk);
      check(log_n - base == NW && !busy, "R7 no restart", 32'(log_n - base), NW);
   endtask

   task automatic t_read();
      bit seen;
      int rbase = rd_n;
      int wbase = log_n;
      logic [15:0] expv = mem[7'h15];
      @(negedge clk); rd_addr = 7'h15; rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      wait_for(2, 200, seen);
      check(seen, "R5 rd_valid", 32'(seen), 1);
      check(rd_data == expv, "R5 rd_data", 32'(rd_data), 32'(expv));
      check(rd_n - rbase == 1 && rd_last == 7'h15, "R5 read strobe", 32'(rd_last), 32'h15);
      check(log_n == wbase, "R5 no write", 32'(log_n - wbase), 0);
      @(negedge clk);
      check(!rd_valid, "R5 pulse", 32'(rd_valid), 0);
   endtask

   task automatic t_lock_drop();
      check(locked, "R10 before drop", 32'(locked), 1);
      lock_drop = 1'b1;
      repeat (3) @(negedge clk);
      check(!locked, "R10 fell with lock", 32'(locked), 0);
      lock_drop = 1'b0;
      repeat (20) @(negedge clk);
      check(prim_locked && !locked, "R10 sticky low", 32'(locked), 0);
   endtask

   task automatic t_ready_timeout();
      bit seen;
      int base = log_n;
      int dbase = done_cnt;
      block_rdy = 1'b1;
      tmo_limit = 16'd20;
      cfg_words = make_words(16'h0F0F);
      pulse_start();
      wait_for(1, 200, seen);
      check(seen, "R8 err", 32'(seen), 1);
      check(!prim_rst && !busy, "R8 released", {prim_rst, busy}, 0);
      repeat (20) @(negedge clk);
      check(log_n - base == 1, "R8 stopped", 32'(log_n - base), 1);
      check(done_cnt == dbase, "R8 no done", 32'(done_cnt - dbase), 0);
      block_rdy = 1'b0;
   endtask

   task automatic t_lock_timeout();
      bit seen;
      int base = log_n;
      int dbase = done_cnt;
      lock_never = 1'b1;
      tmo_limit = 16'd30;
      lat = 1;
      cfg_words = make_words(16'h6666);
      pulse_start();
      check(!err, "R8 err cleared on start", 32'(err), 0);
      wait_for(1, 1000, seen);
      check(seen, "R9 err", 32'(seen), 1);
      check(log_n - base == NW, "R9 all written", 32'(log_n - base), NW);
      check(done_cnt == dbase && !locked && !busy, "R9 no done", 32'(done_cnt - dbase), 0);
      lock_never = 1'b0;
      tmo_limit = 16'd200;
   endtask

   // ---------------- main ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_config(16'h1234, 2, "R2 basic");
      t_config(16'hBEEF, 0, "R2 fast");
      t_ignore_start();
      t_read();
      t_lock_drop();
      t_ready_timeout();
      t_lock_timeout();
      t_config(16'h5A5A, 3, "R2 recover");
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule